// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder for a 16-bit Register Subset

This block sits behind an instruction fetch path and turns a stream of code bytes into decoded instruction records. Bytes arrive one at a time over a valid/ready handshake. Each accepted byte is either the first byte of a new instruction or part of an immediate that is still being collected. When the final byte of an instruction has been accepted, the block presents one record on its output handshake. The record holds the operation class, the register index, the assembled 16-bit immediate, the instruction length in bytes and the opcode byte.

The recognised subset has three parts. The first is five opcodes whose operands are implicit, so the instruction is complete in one byte. The second is a one-byte register push, where the register index sits in the low three opcode bits. The third is a register load with a 16-bit immediate, where the register index also sits in the low three opcode bits and two immediate bytes follow, low byte first. Any other opcode yields a one-byte record flagged as invalid, and decoding carries on with the next byte.

Top module: `insn_byte_decoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1. A reset asserted partway through an immediate discards the bytes already collected, and the first byte accepted after reset is decoded as an opcode.
- R2: Opcodes 0x37, 0x3F, 0x98, 0xAC and 0xD7 each produce one record with class 2'b01, register 0, immediate 0, length 1, invalid flag 0 and the opcode echoed.
- R3: Opcodes 0x50 through 0x57 each produce one record with class 2'b10, register index equal to the opcode minus 0x50 (AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7), immediate 0, length 1 and invalid flag 0.
- R4: An opcode in 0xB8 through 0xBF, followed by two bytes, produces one record with class 2'b11, register index equal to the opcode minus 0xB8, immediate equal to the first following byte plus 256 times the second, length 3 and the opcode echoed. For example, the bytes BB 34 12 give register 3 and value 0x1234.
- R5: A record becomes valid in the cycle after the clock edge that accepts the last byte of its instruction. No record appears for the opcode byte or the first immediate byte of a load, and a record that is taken at once stays valid for exactly one cycle.
- R6: Any other opcode produces a record with invalid flag 1, class 2'b00, register 0, immediate 0, length 1 and the opcode echoed. The next accepted byte is decoded as a new opcode.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every record field holds its value. When `out_ready` returns high, the pending record is taken and a waiting byte is accepted on the same edge.
- R8: Cycles with `in_valid` low accept nothing and leave the decode progress unchanged, so idle gaps between the bytes of a load do not change its record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Code byte offered |
| in_ready | output | 1 | Decoder can accept a code byte |
| in_byte | input | 8 | Code byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 2 | Class: 00 invalid, 01 implicit, 10 push, 11 load immediate |
| out_reg | output | 3 | Register index |
| out_imm | output | 16 | Assembled immediate |
| out_len | output | 2 | Instruction length in bytes |
| out_bad | output | 1 | Opcode outside the subset |
| out_op | output | 8 | Opcode byte of the instruction |

## Verification
If the phase register is wrong, the error shows up in the very next record. A missed transition into immediate collection turns the two immediate bytes into two separate records. A missed return to opcode decode turns the next opcode into an immediate byte, which changes the load's value and removes a record from the stream. A lane written in the wrong position swaps the bytes of the immediate in the first load record. A fault in the stall path shows up on the first stalled cycle as a raised `in_ready` or a changing field, and a reset that leaves a partial immediate in place turns the first instruction after reset into a load.

// File: rtl/insn_dec_pkg.sv
`timescale 1ns/1ps
package insn_dec_pkg;

  localparam int OP_W      = 8;
  localparam int REG_W     = 3;
  localparam int IMM_BYTES = 2;
  localparam int IMM_W     = 8 * IMM_BYTES;
  localparam int LEN_W     = $clog2(IMM_BYTES + 2);
  localparam int IMPL_N    = 5;

  localparam logic [OP_W-1:0] PUSH_BASE = 8'h50;
  localparam logic [OP_W-1:0] LDI_BASE  = 8'hB8;

  localparam logic [OP_W-1:0] IMPL_OPS [IMPL_N] = '{8'h37, 8'h3F, 8'h98, 8'hAC, 8'hD7};

  typedef enum logic [1:0] {
    KIND_BAD  = 2'b00,
    KIND_IMPL = 2'b01,
    KIND_PUSH = 2'b10,
    KIND_LDI  = 2'b11
  } insn_kind_e;

  typedef enum logic {
    PH_OPCODE = 1'b0,
    PH_IMMED  = 1'b1
  } dec_phase_e;

  typedef struct packed {
    logic             bad;
    insn_kind_e       kind;
    logic [REG_W-1:0] rsel;
    logic [IMM_W-1:0] imm;
    logic [LEN_W-1:0] len;
    logic [OP_W-1:0]  op;
  } insn_rec_t;

endpackage

// File: rtl/insn_opc_classify.sv
`timescale 1ns/1ps
module insn_opc_classify
  import insn_dec_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int RW   = REG_W,
  parameter int NIMP = IMPL_N
) (
  input  logic [OPW-1:0] op,
  output insn_kind_e     kind,
  output logic [RW-1:0]  rsel,
  output logic           needs_imm
);

  localparam int FAM_W = OPW - RW;

  logic [NIMP-1:0] impl_hit;
  logic            push_hit;
  logic            ldi_hit;

  genvar g;
  generate
    for (g = 0; g < NIMP; g++) begin : g_impl
      assign impl_hit[g] = (op == IMPL_OPS[g]);
    end
  endgenerate

  assign push_hit = (op[OPW-1:RW] == PUSH_BASE[OPW-1:RW]);
  assign ldi_hit  = (op[OPW-1:RW] == LDI_BASE[OPW-1:RW]);

  always_comb begin
    kind      = KIND_BAD;
    rsel      = '0;
    needs_imm = 1'b0;
    if (|impl_hit) begin
      kind = KIND_IMPL;
    end else if (push_hit) begin
      kind = KIND_PUSH;
      rsel = op[RW-1:0];
    end else if (ldi_hit) begin
      kind      = KIND_LDI;
      rsel      = op[RW-1:0];
      needs_imm = 1'b1;
    end
  end

  logic [FAM_W-1:0] unused_fam;
  assign unused_fam = '0;

endmodule

// File: rtl/insn_imm_gather.sv
`timescale 1ns/1ps
module insn_imm_gather
  import insn_dec_pkg::*;
#(
  parameter int NBYTES = IMM_BYTES,
  parameter int RW     = REG_W,
  parameter int OPW    = OP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [RW-1:0]        start_reg,
  input  logic [OPW-1:0]       start_op,
  input  logic                 take,
  input  logic [7:0]           byte_in,
  output logic                 busy,
  output logic                 last,
  output logic [8*NBYTES-1:0]  imm_full,
  output logic [RW-1:0]        pend_reg,
  output logic [OPW-1:0]       pend_op
);

  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int NSTO  = (NBYTES > 1) ? NBYTES - 1 : 1;

  dec_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [RW-1:0]    reg_q, reg_d;
  logic [OPW-1:0]   op_q, op_d;
  logic [7:0]       lane_q [NSTO];
  logic [NSTO-1:0]  lane_we;

  assign busy     = (phase_q == PH_IMMED);
  assign last     = busy && (idx_q == IDX_W'(NBYTES - 1));
  assign pend_reg = reg_q;
  assign pend_op  = op_q;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    reg_d   = reg_q;
    op_d    = op_q;
    if (phase_q == PH_OPCODE) begin
      if (start) begin
        phase_d = PH_IMMED;
        idx_d   = '0;
        reg_d   = start_reg;
        op_d    = start_op;
      end
    end else if (take) begin
      if (last) begin
        phase_d = PH_OPCODE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPCODE;
      idx_q   <= '0;
      reg_q   <= '0;
      op_q    <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      reg_q   <= reg_d;
      op_q    <= op_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSTO; g++) begin : g_lane
      assign lane_we[g] = take && busy && (idx_q == IDX_W'(g)) && (g < NBYTES - 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q[g] <= '0;
        end else if (lane_we[g]) begin
          lane_q[g] <= byte_in;
        end
      end
    end
    for (g = 0; g < NBYTES; g++) begin : g_asm
      if (g == NBYTES - 1) begin : g_top
        assign imm_full[8*g +: 8] = byte_in;
      end else begin : g_low
        assign imm_full[8*g +: 8] = lane_q[g];
      end
    end
  endgenerate

endmodule

// File: rtl/insn_rec_stage.sv
`timescale 1ns/1ps
module insn_rec_stage
  import insn_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  insn_rec_t rec_in,
  input  logic      out_ready,
  output logic      out_valid,
  output insn_rec_t rec_out,
  output logic      space
);

  logic      vld_q, vld_d;
  insn_rec_t rec_q;

  assign space     = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign rec_out   = rec_q;

  always_comb begin
    vld_d = vld_q;
    if (load) begin
      vld_d = 1'b1;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (load) begin
      rec_q <= rec_in;
    end
  end

endmodule

// File: rtl/insn_byte_decoder.sv
`timescale 1ns/1ps
module insn_byte_decoder
  import insn_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [REG_W-1:0] out_reg,
  output logic [IMM_W-1:0] out_imm,
  output logic [LEN_W-1:0] out_len,
  output logic             out_bad,
  output logic [OP_W-1:0]  out_op
);

  logic             acc;
  insn_kind_e       cls_kind;
  logic [REG_W-1:0] cls_reg;
  logic             cls_imm;
  logic             g_busy, g_last;
  logic [IMM_W-1:0] g_imm;
  logic [REG_W-1:0] g_reg;
  logic [OP_W-1:0]  g_op;
  logic             start_imm, take_imm, fire_short, fire_long, load;
  logic             space;
  insn_rec_t        rec_d, rec_q;

  assign in_ready   = space;
  assign acc        = in_valid && space;
  assign start_imm  = acc && !g_busy && cls_imm;
  assign fire_short = acc && !g_busy && !cls_imm;
  assign take_imm   = acc && g_busy;
  assign fire_long  = take_imm && g_last;
  assign load       = fire_short || fire_long;

  insn_opc_classify u_cls (
    .op        (in_byte),
    .kind      (cls_kind),
    .rsel      (cls_reg),
    .needs_imm (cls_imm)
  );

  insn_imm_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_imm),
    .start_reg (cls_reg),
    .start_op  (in_byte),
    .take      (take_imm),
    .byte_in   (in_byte),
    .busy      (g_busy),
    .last      (g_last),
    .imm_full  (g_imm),
    .pend_reg  (g_reg),
    .pend_op   (g_op)
  );

  always_comb begin
    if (fire_long) begin
      rec_d.bad  = 1'b0;
      rec_d.kind = KIND_LDI;
      rec_d.rsel = g_reg;
      rec_d.imm  = g_imm;
      rec_d.len  = LEN_W'(IMM_BYTES + 1);
      rec_d.op   = g_op;
    end else begin
      rec_d.bad  = (cls_kind == KIND_BAD);
      rec_d.kind = cls_kind;
      rec_d.rsel = cls_reg;
      rec_d.imm  = '0;
      rec_d.len  = LEN_W'(1);
      rec_d.op   = in_byte;
    end
  end

  insn_rec_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .rec_in    (rec_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_out   (rec_q),
    .space     (space)
  );

  assign out_kind = rec_q.kind;
  assign out_reg  = rec_q.rsel;
  assign out_imm  = rec_q.imm;
  assign out_len  = rec_q.len;
  assign out_bad  = rec_q.bad;
  assign out_op   = rec_q.op;

endmodule

// File: rtl/insn_byte_decoder_chk.sv
`timescale 1ns/1ps
module insn_byte_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic [2:0]  out_reg,
  input logic [15:0] out_imm,
  input logic [1:0]  out_len,
  input logic        out_bad,
  input logic [7:0]  out_op
);

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_STALL_HOLDS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_kind, out_reg, out_imm, out_len, out_bad, out_op}))); // R7

  AST_RECORD_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R5

  AST_SHORT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'b11) |-> (out_len == 2'd1 && out_imm == 16'h0000)); // R2

  AST_LOAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'b11) |-> (out_len == 2'd3 && out_op[7:3] == 5'b10111 && out_reg == out_op[2:0])); // R4

  AST_PUSH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'b10) |-> (out_op[7:3] == 5'b01010 && out_reg == out_op[2:0])); // R3

  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bad == (out_kind == 2'b00))); // R6

  AST_IMPLICIT_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'b01) |-> (out_reg == 3'd0)); // R2

endmodule

bind insn_byte_decoder insn_byte_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_kind  (out_kind),
  .out_reg   (out_reg),
  .out_imm   (out_imm),
  .out_len   (out_len),
  .out_bad   (out_bad),
  .out_op    (out_op)
);

// File: tb/test_insn_byte_decoder.sv
`timescale 1ns/1ps
module test_insn_byte_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_kind;
  logic [2:0]  out_reg;
  logic [15:0] out_imm;
  logic [1:0]  out_len;
  logic        out_bad;
  logic [7:0]  out_op;

  always #2 clk = ~clk;

  insn_byte_decoder i_insn_byte_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_reg   (out_reg),
    .out_imm   (out_imm),
    .out_len   (out_len),
    .out_bad   (out_bad),
    .out_op    (out_op)
  );

  // record layout: {bad, kind[1:0], reg[2:0], imm[15:0], len[1:0], op[7:0]}
  localparam int NS = 23;
  localparam int NE = 17;
  localparam logic [7:0] STIM [NS] = '{
    8'h37, 8'h3F, 8'h98, 8'hAC, 8'hD7, 8'h51, 8'h50, 8'h57,
    8'hB8, 8'h01, 8'h00, 8'hBB, 8'h34, 8'h12, 8'hBF, 8'hFF, 8'hFF,
    8'h00, 8'h90, 8'h58, 8'hB7, 8'h36, 8'h54
  };
  localparam logic [31:0] EXP [NE] = '{
    {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'h37},
    {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'h3F},
    {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'h98},
    {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'hAC},
    {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'hD7},
    {1'b0, 2'd2, 3'd1, 16'h0000, 2'd1, 8'h51},
    {1'b0, 2'd2, 3'd0, 16'h0000, 2'd1, 8'h50},
    {1'b0, 2'd2, 3'd7, 16'h0000, 2'd1, 8'h57},
    {1'b0, 2'd3, 3'd0, 16'h0001, 2'd3, 8'hB8},
    {1'b0, 2'd3, 3'd3, 16'h1234, 2'd3, 8'hBB},
    {1'b0, 2'd3, 3'd7, 16'hFFFF, 2'd3, 8'hBF},
    {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'h00},
    {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'h90},
    {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'h58},
    {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'hB7},
    {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'h36},
    {1'b0, 2'd2, 3'd4, 16'h0000, 2'd1, 8'h54}
  };

  localparam logic [31:0] REC_PUSH_CX = {1'b0, 2'd2, 3'd1, 16'h0000, 2'd1, 8'h51};
  localparam logic [31:0] REC_AAA     = {1'b0, 2'd1, 3'd0, 16'h0000, 2'd1, 8'h37};

  int n_chk = 0;
  int n_bad = 0;
  int mon_idx = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  function automatic logic [31:0] rec_now();
    return {out_bad, out_kind, out_reg, out_imm, out_len, out_op};
  endfunction

  task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge, in_valid left high
  task automatic send(input logic [7:0] b);
    bit ok;
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] k);
    case (k)
      2'd1:    return "R2";
      2'd2:    return "R3";
      2'd3:    return "R4";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      if (mon_idx < NE) begin
        check(rec_now() == EXP[mon_idx], tag_of(EXP[mon_idx][29:28]), rec_now(), EXP[mon_idx]);
      end else begin
        check(1'b0, "R5", rec_now(), 32'h0);
      end
      mon_idx++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    report();
  end

  initial begin
    in_valid  = 1'b0;
    in_byte   = 8'h00;
    out_ready = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk
    mon_en = 1'b1;
    for (int i = 0; i < NS; i++) begin
      send(STIM[i]);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    check(mon_idx == NE, "R5", 32'(mon_idx), 32'(NE));

    // R5: record timing for a load
    send(8'hB8);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5", 32'(out_valid), 32'h0);
    send(8'h01);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5", 32'(out_valid), 32'h0);
    send(8'h00);
    in_valid = 1'b0;
    check(out_valid && rec_now() == {1'b0, 2'd3, 3'd0, 16'h0001, 2'd3, 8'hB8}, "R5", rec_now(),
          {1'b0, 2'd3, 3'd0, 16'h0001, 2'd3, 8'hB8});
    @(negedge clk);
    check(out_valid == 1'b0, "R5", 32'(out_valid), 32'h0);

    // R8: idle gaps inside a load
    send(8'hBB);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", 32'(out_valid), 32'h0);
    send(8'h34);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8", 32'(out_valid), 32'h0);
    send(8'h12);
    in_valid = 1'b0;
    check(out_valid && rec_now() == {1'b0, 2'd3, 3'd3, 16'h1234, 2'd3, 8'hBB}, "R8", rec_now(),
          {1'b0, 2'd3, 3'd3, 16'h1234, 2'd3, 8'hBB});
    @(negedge clk);

    // R7: stalled output
    out_ready = 1'b0;
    send(8'h51);
    in_valid = 1'b1;
    in_byte  = 8'h37;
    check(out_valid && rec_now() == REC_PUSH_CX, "R7", rec_now(), REC_PUSH_CX);
    for (int k = 0; k < 3; k++) begin
      check(in_ready == 1'b0, "R7", 32'(in_ready), 32'h0);
      @(negedge clk);
      check(out_valid && rec_now() == REC_PUSH_CX, "R7", rec_now(), REC_PUSH_CX);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && rec_now() == REC_AAA, "R7", rec_now(), REC_AAA);
    @(negedge clk);

    // R1: reset in the middle of an immediate
    send(8'hB9);
    send(8'h11);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h37);
    in_valid = 1'b0;
    check(out_valid && rec_now() == REC_AAA, "R1", rec_now(), REC_AAA);
    @(negedge clk);

    // R6: invalid opcode then resume
    send(8'hFF);
    in_valid = 1'b0;
    check(out_valid && rec_now() == {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'hFF}, "R6", rec_now(),
          {1'b1, 2'd0, 3'd0, 16'h0000, 2'd1, 8'hFF});
    send(8'h52);
    in_valid = 1'b0;
    check(out_valid && rec_now() == {1'b0, 2'd2, 3'd2, 16'h0000, 2'd1, 8'h52}, "R6", rec_now(),
          {1'b0, 2'd2, 3'd2, 16'h0000, 2'd1, 8'h52});
    repeat (2) @(negedge clk);
    report();
  end

endmodule